// File: doc/BRIEF.md
# SPI Master Register Bank

This block is the software-facing front end of an SPI master. A simple register bus reaches it with a byte address, separate read and write strobes, and 64-bit data. It holds nine 64-bit registers: error, counter setup, general configuration, clock and reset control, memory window mapping, transmit data, receive data, eight sequencer operation slots, and status. Bit 0 is the most significant bit in all field descriptions. The register number is the byte address divided by eight.

A shift engine sits beside the block. It reads the transmit data, the configuration and the sequencer slots from output ports. It loads received words, takes transmit words, and reports its state machine codes through sideband inputs. The bank keeps the full, overrun and underrun flags for both data registers consistent with bus and engine activity. It also watches the reset-control field of the clock register for a two-write unlock key.

Top module: `spi_regbank`

## Requirements
- R1: A read strobe returns the register selected by address bits [ADDR_W-1:3] on bus_rdata one cycle later. Register numbers: error 0, counter 1, configuration 2, clock 3, mapping 4, transmit 5, receive 6, sequencer 7, status 8. Registers 0 to 4 read back exactly what was last written to them.
- R2: A read of a register number above 8 returns all ones. Any read or write to such a number pulses bus_bad for one cycle, and the write changes no register.
- R3: Reading the receive register clears RDR-full (status bit 0). Reading it while RDR-full is clear sets RDR-underrun (bit 2).
- R4: An engine load strobe stores eng_rdr_data in the receive register, sets RDR-full and clears RDR-underrun. If RDR-full was already set, it also sets RDR-overrun (bit 1).
- R5: A write to the transmit register stores the value on tdr_data, sets TDR-full (bit 4) and clears TDR-underrun (bit 6). If TDR-full was already set, the write also sets TDR-overrun (bit 5).
- R6: An engine take strobe clears TDR-full. A take while TDR-full is clear sets TDR-underrun.
- R7: When the clock register's reset-control field (bits 24-27) holds 0x5, a write whose field is 0xA loads 0x0084000000000000 instead of the written value. Every other write stores the value unchanged.
- R8: The sequencer register is eight byte slots, with slot 0 in the most significant byte on both read and write.
- R9: The status register shows the engine's sequencer state in bits 8-15, its shifter state in bits 16-27, the sequencer index in bits 28-31 and general status in bits 32-63. Bits 3 and 7 read as zero. A status write changes only RDR-overrun and TDR-overrun, each taking the written bit at its own position.
- R10: After synchronous reset, every register and flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_bad | output | 1 | Pulse for an access to an undefined register |
| eng_rdr_load | input | 1 | Engine delivers a received word |
| eng_rdr_data | input | 64 | Received word |
| eng_tdr_take | input | 1 | Engine consumes the transmit word |
| eng_seq_state | input | 8 | Sequencer state code (one-hot) |
| eng_shift_state | input | 12 | Shifter state code (one-hot) |
| eng_seq_index | input | 4 | Current sequencer slot index |
| eng_gen_status | input | 32 | General engine status |
| tdr_data | output | 64 | Transmit register contents |
| seq_slots | output | 64 | Sequencer slots, slot 0 in the top byte |
| cnt_cfg | output | 64 | Counter setup register |
| gen_cfg | output | 64 | Configuration register |
| clk_cfg | output | 64 | Clock and reset control register |
| map_cfg | output | 64 | Memory window mapping register |

## Verification
Assertions check the flag rules on every cycle. A receive read leaves RDR-full clear, and a load onto a full register raises overrun. A transmit write leaves full set and underrun clear. An armed key write yields the fixed clock value, and an undefined read returns all ones with bus_bad. Only the bench's scenarios show whole flag histories across mixed bus and engine traffic. The same holds for status write masking against live engine fields, slot byte order, and the fact that a stray write disturbs no register.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  localparam int DW = 64;

  // register numbers (address >> 3)
  localparam int IX_ERR  = 0;
  localparam int IX_CNT  = 1;
  localparam int IX_CFG  = 2;
  localparam int IX_CLK  = 3;
  localparam int IX_MAP  = 4;
  localparam int IX_TDR  = 5;
  localparam int IX_RDR  = 6;
  localparam int IX_SEQ  = 7;
  localparam int IX_STAT = 8;
  localparam int NUM_REGS = 9;

  // status flag positions, LSB-0 numbering (MSB-0 bit k is 63-k)
  localparam int ST_RFULL  = 63;
  localparam int ST_ROVR   = 62;
  localparam int ST_RUNDER = 61;
  localparam int ST_TFULL  = 59;
  localparam int ST_TOVR   = 58;
  localparam int ST_TUNDER = 57;
endpackage

// File: rtl/spi_rb_flags.sv
module spi_rb_flags
  import spi_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rdr_load,
  input  logic          rdr_read,
  input  logic          tdr_write,
  input  logic          tdr_take,
  input  logic          stat_write,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    seq_state,
  input  logic [11:0]   shift_state,
  input  logic [3:0]    seq_index,
  input  logic [31:0]   gen_status,
  output logic [DW-1:0] status
);
  logic r_full, r_ovr, r_under, t_full, t_ovr, t_under;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_full <= 1'b0; r_ovr <= 1'b0; r_under <= 1'b0;
      t_full <= 1'b0; t_ovr <= 1'b0; t_under <= 1'b0;
    end else begin
      // receive side: engine load takes priority over a bus read
      if (rdr_load)      r_full <= 1'b1;
      else if (rdr_read) r_full <= 1'b0;

      if (rdr_load && r_full) r_ovr <= 1'b1;
      else if (stat_write)    r_ovr <= wdata[ST_ROVR];

      if (rdr_load)                 r_under <= 1'b0;
      else if (rdr_read && !r_full) r_under <= 1'b1;

      // transmit side: bus write takes priority over an engine take
      if (tdr_write)     t_full <= 1'b1;
      else if (tdr_take) t_full <= 1'b0;

      if (tdr_write && t_full) t_ovr <= 1'b1;
      else if (stat_write)     t_ovr <= wdata[ST_TOVR];

      if (tdr_write)                t_under <= 1'b0;
      else if (tdr_take && !t_full) t_under <= 1'b1;
    end
  end

  assign status = {r_full, r_ovr, r_under, 1'b0, t_full, t_ovr, t_under, 1'b0,
                   seq_state, shift_state, seq_index, gen_status};

  p_rdr_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (rdr_read && !rdr_load) |=> !status[ST_RFULL]);
  p_load_on_full_r4: assert property (@(posedge clk) disable iff (rst)
    (rdr_load && status[ST_RFULL]) |=> (status[ST_ROVR] && status[ST_RFULL]));
  p_tdr_write_r5: assert property (@(posedge clk) disable iff (rst)
    tdr_write |=> (status[ST_TFULL] && !status[ST_TUNDER]));
  p_take_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (tdr_take && !tdr_write && !status[ST_TFULL]) |=> status[ST_TUNDER]);
endmodule

// File: rtl/spi_rb_clkkey.sv
module spi_rb_clkkey #(
  parameter int          W       = 64,
  parameter int          KEY_LSB = 36,
  parameter int          KEY_W   = 4,
  parameter logic [3:0]  ARM     = 4'h5,
  parameter logic [3:0]  FIRE    = 4'hA,
  parameter logic [63:0] RST_VAL = 64'h0084_0000_0000_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic armed, fire;
  assign armed = (q[KEY_LSB +: KEY_W] == ARM[KEY_W-1:0]);
  assign fire  = (wdata[KEY_LSB +: KEY_W] == FIRE[KEY_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (armed && fire) ? RST_VAL[W-1:0] : wdata;
  end

  p_key_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (we && armed && fire) |=> (q == RST_VAL[W-1:0]));
  p_plain_store_r7: assert property (@(posedge clk) disable iff (rst)
    (we && !(armed && fire)) |=> (q == $past(wdata)));
endmodule

// File: rtl/spi_rb_slots.sv
module spi_rb_slots #(
  parameter int W     = 64,
  parameter int SLOTS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] slots
);
  localparam int SW = W / SLOTS;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [SW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)     slot_q <= '0;
      else if (we) slot_q <= wdata[W-1-i*SW -: SW];
    end
    // slot 0 sits in the most significant byte
    assign slots[W-1-i*SW -: SW] = slot_q;
  end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_bad,
  input  logic              eng_rdr_load,
  input  logic [63:0]       eng_rdr_data,
  input  logic              eng_tdr_take,
  input  logic [7:0]        eng_seq_state,
  input  logic [11:0]       eng_shift_state,
  input  logic [3:0]        eng_seq_index,
  input  logic [31:0]       eng_gen_status,
  output logic [63:0]       tdr_data,
  output logic [63:0]       seq_slots,
  output logic [63:0]       cnt_cfg,
  output logic [63:0]       gen_cfg,
  output logic [63:0]       clk_cfg,
  output logic [63:0]       map_cfg
);
  localparam int IW = ADDR_W - 3;

  logic [IW-1:0] idx;
  logic          valid_ix;
  logic          w_err, w_cnt, w_cfg, w_clk, w_map, w_tdr, w_rdr, w_seq, w_stat;
  logic          r_rdr;
  logic [DW-1:0] err_q, rdr_q, status, rd_mux;

  assign idx      = bus_addr[ADDR_W-1:3];
  assign valid_ix = (idx < IW'(NUM_REGS));

  assign w_err  = bus_wr && (idx == IW'(IX_ERR));
  assign w_cnt  = bus_wr && (idx == IW'(IX_CNT));
  assign w_cfg  = bus_wr && (idx == IW'(IX_CFG));
  assign w_clk  = bus_wr && (idx == IW'(IX_CLK));
  assign w_map  = bus_wr && (idx == IW'(IX_MAP));
  assign w_tdr  = bus_wr && (idx == IW'(IX_TDR));
  assign w_rdr  = bus_wr && (idx == IW'(IX_RDR));
  assign w_seq  = bus_wr && (idx == IW'(IX_SEQ));
  assign w_stat = bus_wr && (idx == IW'(IX_STAT));
  assign r_rdr  = bus_rd && (idx == IW'(IX_RDR));

  // plain storage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0; cnt_cfg <= '0; gen_cfg <= '0; map_cfg <= '0;
      tdr_data <= '0; rdr_q <= '0;
    end else begin
      if (w_err) err_q    <= bus_wdata;
      if (w_cnt) cnt_cfg  <= bus_wdata;
      if (w_cfg) gen_cfg  <= bus_wdata;
      if (w_map) map_cfg  <= bus_wdata;
      if (w_tdr) tdr_data <= bus_wdata;
      if (eng_rdr_load) rdr_q <= eng_rdr_data;
      else if (w_rdr)   rdr_q <= bus_wdata;
    end
  end

  spi_rb_clkkey #(.W(DW)) u_clk (
    .clk(clk), .rst(rst), .we(w_clk), .wdata(bus_wdata), .q(clk_cfg)
  );

  spi_rb_slots #(.W(DW), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst(rst), .we(w_seq), .wdata(bus_wdata), .slots(seq_slots)
  );

  spi_rb_flags u_flags (
    .clk(clk), .rst(rst),
    .rdr_load(eng_rdr_load), .rdr_read(r_rdr),
    .tdr_write(w_tdr), .tdr_take(eng_tdr_take),
    .stat_write(w_stat), .wdata(bus_wdata),
    .seq_state(eng_seq_state), .shift_state(eng_shift_state),
    .seq_index(eng_seq_index), .gen_status(eng_gen_status),
    .status(status)
  );

  always_comb begin
    rd_mux = '1;
    case (idx)
      IW'(IX_ERR):  rd_mux = err_q;
      IW'(IX_CNT):  rd_mux = cnt_cfg;
      IW'(IX_CFG):  rd_mux = gen_cfg;
      IW'(IX_CLK):  rd_mux = clk_cfg;
      IW'(IX_MAP):  rd_mux = map_cfg;
      IW'(IX_TDR):  rd_mux = tdr_data;
      IW'(IX_RDR):  rd_mux = rdr_q;
      IW'(IX_SEQ):  rd_mux = seq_slots;
      IW'(IX_STAT): rd_mux = status;
      default:      rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_bad   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      bus_bad <= (bus_rd || bus_wr) && !valid_ix;
    end
  end

  p_bad_read_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !valid_ix) |=> (bus_bad && (bus_rdata == '1)));
  p_no_bad_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && valid_ix) |=> !bus_bad);
endmodule

// File: tb/sim_spi_regbank.sv
`timescale 1ns/1ps
module sim_spi_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_bad;
  logic        eng_rdr_load = 1'b0;
  logic [63:0] eng_rdr_data = '0;
  logic        eng_tdr_take = 1'b0;
  logic [7:0]  eng_seq_state = '0;
  logic [11:0] eng_shift_state = '0;
  logic [3:0]  eng_seq_index = '0;
  logic [31:0] eng_gen_status = '0;
  logic [63:0] tdr_data, seq_slots, cnt_cfg, gen_cfg, clk_cfg, map_cfg;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  spi_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_bad(bus_bad),
    .eng_rdr_load(eng_rdr_load), .eng_rdr_data(eng_rdr_data),
    .eng_tdr_take(eng_tdr_take), .eng_seq_state(eng_seq_state),
    .eng_shift_state(eng_shift_state), .eng_seq_index(eng_seq_index),
    .eng_gen_status(eng_gen_status), .tdr_data(tdr_data), .seq_slots(seq_slots),
    .cnt_cfg(cnt_cfg), .gen_cfg(gen_cfg), .clk_cfg(clk_cfg), .map_cfg(map_cfg)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks: inputs change on the falling edge
  task automatic wr(input int ix, input logic [63:0] d);
    @(negedge clk);
    bus_addr = 8'(ix * 8); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ix, input logic [63:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 8'(ix * 8); bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic eng_load(input logic [63:0] d);
    @(negedge clk);
    eng_rdr_data = d; eng_rdr_load = 1'b1;
    @(negedge clk);
    eng_rdr_load = 1'b0;
  endtask

  task automatic eng_take();
    @(negedge clk);
    eng_tdr_take = 1'b1;
    @(negedge clk);
    eng_tdr_take = 1'b0;
  endtask

  // monitor: a read strobe seen at a rising edge yields data by the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
        end else begin
          chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: everything zero after reset (receive read when empty sets underrun, R3)
    for (int i = 0; i < 8; i++) rd(i, 64'h0, "R10 reset value");
    rd(8, 64'h2000_0000_0000_0000, "R3 underrun on empty read");

    // R1: storage registers read back
    wr(0, 64'h1111_0000_0000_0001);
    wr(1, 64'h2222_0000_0000_0002);
    wr(2, 64'h3333_0000_0000_0003);
    wr(4, 64'hA5A5_5A5A_F0F0_0F0F);
    rd(0, 64'h1111_0000_0000_0001, "R1 error reg");
    rd(1, 64'h2222_0000_0000_0002, "R1 counter reg");
    rd(2, 64'h3333_0000_0000_0003, "R1 config reg");
    rd(4, 64'hA5A5_5A5A_F0F0_0F0F, "R1 mapping reg");
    chk(map_cfg, 64'hA5A5_5A5A_F0F0_0F0F, "R1 mapping port");

    // R8: slot order
    wr(7, 64'h0102_0304_0506_0708);
    rd(7, 64'h0102_0304_0506_0708, "R8 slots readback");
    chk({56'h0, seq_slots[63:56]}, 64'h01, "R8 slot0 in top byte");

    // R5: transmit write, then write on full
    wr(5, 64'hDEAD);
    rd(8, 64'h2800_0000_0000_0000, "R5 TDR full");
    wr(5, 64'hBEEF);
    rd(8, 64'h2C00_0000_0000_0000, "R5 TDR overrun");
    rd(5, 64'hBEEF, "R5 TDR readback");
    chk(tdr_data, 64'hBEEF, "R5 tdr port");

    // R6: take, then take on empty, then write clears underrun
    eng_take();
    rd(8, 64'h2400_0000_0000_0000, "R6 take clears full");
    eng_take();
    rd(8, 64'h2600_0000_0000_0000, "R6 underrun");
    wr(5, 64'h1);
    rd(8, 64'h2C00_0000_0000_0000, "R5 write clears underrun");

    // R4: engine loads
    eng_load(64'hAA);
    rd(8, 64'h8C00_0000_0000_0000, "R4 RDR full");
    eng_load(64'hBB);
    rd(8, 64'hCC00_0000_0000_0000, "R4 RDR overrun");

    // R3: reading the receive register
    rd(6, 64'hBB, "R4 RDR data");
    rd(8, 64'h4C00_0000_0000_0000, "R3 read clears full");
    rd(6, 64'hBB, "R3 empty read data");
    rd(8, 64'h6C00_0000_0000_0000, "R3 empty read underrun");

    // R9: status write masking and engine fields
    wr(8, 64'h0);
    rd(8, 64'h2800_0000_0000_0000, "R9 overruns cleared");
    wr(8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8, 64'h6C00_0000_0000_0000, "R9 only overruns set");
    @(negedge clk);
    eng_seq_state = 8'h04; eng_shift_state = 12'h020;
    eng_seq_index = 4'h3; eng_gen_status = 32'h1234_5678;
    wr(8, 64'h0);
    rd(8, 64'h2804_0203_1234_5678, "R9 engine fields");

    // R7: reset key in the clock register
    wr(3, 64'h0000_0050_0000_0000);
    rd(3, 64'h0000_0050_0000_0000, "R7 arm stored");
    wr(3, 64'h0000_00A0_FFFF_FFFF);
    rd(3, 64'h0084_0000_0000_0000, "R7 key fires");
    chk(clk_cfg, 64'h0084_0000_0000_0000, "R7 clock port");
    wr(3, 64'h0000_00A0_FFFF_FFFF);
    rd(3, 64'h0000_00A0_FFFF_FFFF, "R7 unarmed A stored");
    wr(3, 64'h0000_0050_0000_0000);
    wr(3, 64'h0000_0030_0000_0007);
    rd(3, 64'h0000_0030_0000_0007, "R7 wrong second key");

    // R2: undefined register numbers
    rd(9, 64'hFFFF_FFFF_FFFF_FFFF, "R2 undefined read");
    chk({63'h0, bus_bad}, 64'h1, "R2 bad on read");
    wr(12, 64'h0);
    chk({63'h0, bus_bad}, 64'h1, "R2 bad on write");
    rd(0, 64'h1111_0000_0000_0001, "R2 stray write no effect");
    chk({63'h0, bus_bad}, 64'h0, "R2 no bad on valid");
    rd(2, 64'h3333_0000_0000_0003, "R2 stray write no effect cfg");

    repeat (4) @(negedge clk);
    chk(64'(exp_q.size()), 64'h0, "R1 all reads returned");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule